// File: doc/BRIEF.md
# Stallable Quadword Receive Buffer

This block is the sink end of a DMA stream. An upstream engine presents 128-bit quadwords with a valid/ready/last handshake. Each accepted beat is written into the next free slot of a small on-chip buffer, beginning at slot 0. The block tracks how many beats have arrived. It also holds a sticky flag that records that the closing beat of a transfer was taken.

A stall input lets surrounding logic or a test harness refuse data. While stall is high, ready stays low and nothing changes. Ready also drops once every slot is occupied, so stored data is never overwritten. The full condition is reported on its own output.

Stored quadwords can be inspected through an indexed read port that answers one cycle after the request. Every accepted beat also produces a one-cycle write event carrying the slot index and the last marker, for trace collection.

Top module: `qword_rx_buffer`

## Requirements
- R1: After reset, the beat count is 0, the last flag is 0, full is 0, the read strobe and write event are 0, and ready is 1 while stall is low.
- R2: While `stall_req` is high, `in_ready` is 0, no beat is taken even with `in_valid` and `in_last` high, and the beat count, last flag and event output do not change.
- R3: Accepted beats are stored in slots 0, 1, 2 … in arrival order, and each slot holds the data of its beat.
- R4: The beat count rises by exactly one per accepted beat, so it reads 4 after a four-beat transfer.
- R5: The last flag is set by the first accepted beat with `in_last` high and stays set while later beats without last are accepted.
- R6: A read request (`rd_en` high with `rd_idx`) at a rising edge makes `rd_valid` high with that slot's contents for the single following cycle; without a request, `rd_valid` is low.
- R7: After DEPTH (default 8) beats, `buf_full` is 1 and `in_ready` is 0. Further offered beats change neither the count nor any slot.
- R8: Each accepted beat raises `evt_valid` for exactly the cycle after acceptance, with `evt_slot` equal to the slot written and `evt_last` equal to the beat's last marker. No event is raised in any other cycle.
- R9: Reading a slot that has not been written, in the same cycle a beat is accepted, does not alter that beat's storage or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream beat present |
| in_data | input | DATA_W | Quadword payload |
| in_last | input | 1 | Marks the closing beat of a transfer |
| in_ready | output | 1 | Beat will be taken at the next edge |
| stall_req | input | 1 | Forces ready low |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Slot to read |
| rd_data | output | DATA_W | Read result |
| rd_valid | output | 1 | Read result valid |
| beat_count | output | CNT_W | Accepted beats since reset |
| last_flag | output | 1 | Sticky last-received flag |
| buf_full | output | 1 | All slots occupied |
| evt_valid | output | 1 | Write event strobe |
| evt_slot | output | IDX_W | Slot written by the beat |
| evt_last | output | 1 | Last marker of the beat |

## Verification
Several checks run on every cycle through the assertions. Stall must leave the count still. The count must step by one per acceptance and never exceed the depth. The last flag must not clear. Each acceptance, and only an acceptance, must produce an event one cycle later. Each read request must produce a strobe one cycle later. Other properties depend on data values and on orderings across whole transfers, so only the bench scenarios show them. These are the slot ordering and payload integrity, the refused beats leaving slots untouched when the buffer is full, and a read of an empty slot overlapping a write.

// File: rtl/qrx_pkg.sv
package qrx_pkg;
   // Slot storage initialisation variant
   typedef enum logic [0:0] {
      SLOT_KEEP  = 1'b0,   // slots keep arbitrary content through reset
      SLOT_CLEAR = 1'b1    // slots are zeroed by reset
   } slot_init_e;

   function automatic int idx_width(input int depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction
endpackage

// File: rtl/qrx_admit.sv
module qrx_admit #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 32,
   localparam int IDX_W = qrx_pkg::idx_width(DEPTH),
   localparam int FILL_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_last,
   input  logic             stall_req,
   output logic             in_ready,
   output logic             accept,
   output logic [IDX_W-1:0] wr_slot,
   output logic [CNT_W-1:0] beat_count,
   output logic             last_flag,
   output logic             buf_full
);
   localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);

   logic [FILL_W-1:0] fill_q;
   logic [CNT_W-1:0]  count_q;
   logic              last_q;

   assign buf_full = (fill_q == FILL_MAX);
   assign in_ready = !stall_req && !buf_full;
   assign accept   = in_valid && in_ready;
   assign wr_slot  = fill_q[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q  <= '0;
         count_q <= '0;
         last_q  <= 1'b0;
      end else if (accept) begin
         fill_q  <= fill_q + FILL_W'(1);
         count_q <= count_q + CNT_W'(1);
         if (in_last) last_q <= 1'b1;
      end
   end

   assign beat_count = count_q;
   assign last_flag  = last_q;

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      stall_req |=> beat_count == $past(beat_count)); // R2
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> beat_count == $past(beat_count) + CNT_W'(1)); // R4
   AST_LAST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      last_flag |=> last_flag); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      beat_count <= CNT_W'(DEPTH)); // R7
endmodule

// File: rtl/qrx_store.sv
module qrx_store #(
   parameter int DATA_W = 128,
   parameter int DEPTH = 8,
   parameter qrx_pkg::slot_init_e INIT = qrx_pkg::SLOT_KEEP,
   localparam int IDX_W = qrx_pkg::idx_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_slot,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   logic [DATA_W-1:0] slot_vec [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit = wr_en && (wr_slot == IDX_W'(s));
      if (INIT == qrx_pkg::SLOT_CLEAR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wr_data;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) q <= wr_data;
         end
      end
      assign slot_vec[s] = q;
   end

   logic [DATA_W-1:0] rd_q;
   logic              rv_q;

   always_ff @(posedge clk) begin
      if (rd_en) rd_q <= (32'(rd_idx) < DEPTH) ? slot_vec[rd_idx] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rv_q <= 1'b0;
      else        rv_q <= rd_en;
   end

   assign rd_data  = rd_q;
   assign rd_valid = rv_q;

   AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid); // R6
   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid); // R6
endmodule

// File: rtl/qrx_trace.sv
module qrx_trace #(
   parameter int DEPTH = 8,
   localparam int IDX_W = qrx_pkg::idx_width(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [IDX_W-1:0] wr_slot,
   input  logic             in_last,
   output logic             evt_valid,
   output logic [IDX_W-1:0] evt_slot,
   output logic             evt_last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_valid <= 1'b0;
         evt_slot  <= '0;
         evt_last  <= 1'b0;
      end else begin
         evt_valid <= accept;
         if (accept) begin
            evt_slot <= wr_slot;
            evt_last <= in_last;
         end
      end
   end

   AST_EVT_PER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> evt_valid); // R8
   AST_EVT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> !evt_valid); // R8
   AST_EVT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> evt_slot == $past(wr_slot)); // R8
endmodule

// File: rtl/qword_rx_buffer.sv
module qword_rx_buffer #(
   parameter int DATA_W = 128,
   parameter int DEPTH = 8,
   parameter int CNT_W = 32,
   parameter qrx_pkg::slot_init_e INIT = qrx_pkg::SLOT_KEEP,
   localparam int IDX_W = qrx_pkg::idx_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              in_ready,
   input  logic              stall_req,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [CNT_W-1:0]  beat_count,
   output logic              last_flag,
   output logic              buf_full,
   output logic              evt_valid,
   output logic [IDX_W-1:0]  evt_slot,
   output logic              evt_last
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("qword_rx_buffer: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("qword_rx_buffer: DATA_W must be positive");
   end
   if (CNT_W < IDX_W + 1) begin : g_bad_cnt
      $error("qword_rx_buffer: CNT_W too narrow to hold DEPTH");
   end

   logic             accept;
   logic [IDX_W-1:0] wr_slot;

   qrx_admit #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_admit (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_last    (in_last),
      .stall_req  (stall_req),
      .in_ready   (in_ready),
      .accept     (accept),
      .wr_slot    (wr_slot),
      .beat_count (beat_count),
      .last_flag  (last_flag),
      .buf_full   (buf_full)
   );

   qrx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .INIT(INIT)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (accept),
      .wr_slot  (wr_slot),
      .wr_data  (in_data),
      .rd_en    (rd_en),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   qrx_trace #(.DEPTH(DEPTH)) u_trace (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .wr_slot   (wr_slot),
      .in_last   (in_last),
      .evt_valid (evt_valid),
      .evt_slot  (evt_slot),
      .evt_last  (evt_last)
   );

   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full |=> beat_count == $past(beat_count)); // R7
endmodule

// File: tb/tb_qword_rx_buffer.sv
`timescale 1ns/1ps
module tb_qword_rx_buffer;
   localparam int DW = 128;
   localparam int DP = 8;
   localparam int CW = 32;
   localparam int IW = $clog2(DP);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid, in_last, in_ready, stall_req;
   logic [DW-1:0] in_data;
   logic          rd_en;
   logic [IW-1:0] rd_idx;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic [CW-1:0] beat_count;
   logic          last_flag, buf_full, evt_valid, evt_last;
   logic [IW-1:0] evt_slot;

   always #5 clk = ~clk;

   qword_rx_buffer #(.DATA_W(DW), .DEPTH(DP), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_ready(in_ready), .stall_req(stall_req),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
      .beat_count(beat_count), .last_flag(last_flag), .buf_full(buf_full),
      .evt_valid(evt_valid), .evt_slot(evt_slot), .evt_last(evt_last)
   );

   int checks = 0;
   int errors = 0;
   int evt_seen = 0;

   function automatic logic [DW-1:0] pat(input int i);
      return {4{32'hC0DE_0000 + 32'(i * 17 + 3)}};
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) if (rst_n && evt_valid) evt_seen++;

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 0; in_last = 0; in_data = '0;
      stall_req = 0; rd_en = 0; rd_idx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      chk("R1 count", DW'(beat_count), 0);
      chk("R1 last", DW'(last_flag), 0);
      chk("R1 full", DW'(buf_full), 0);
      chk("R1 rd_valid", DW'(rd_valid), 0);
      chk("R1 evt", DW'(evt_valid), 0);
      chk("R1 ready", DW'(in_ready), 1);
   endtask

   // one beat offered for one cycle, checked after the edge
   task automatic send(input int i, input logic lst, input int exp_cnt);
      in_valid = 1; in_data = pat(i); in_last = lst;
      @(negedge clk);
      in_valid = 0; in_last = 0;
      chk("R4 count", DW'(beat_count), DW'(exp_cnt));
      chk("R8 evt_valid", DW'(evt_valid), 1);
      chk("R8 evt_slot", DW'(evt_slot), DW'(i));
      chk("R8 evt_last", DW'(evt_last), DW'(lst));
   endtask

   task automatic readback(input int idx, input logic [DW-1:0] exp, input string req);
      rd_en = 1; rd_idx = IW'(idx);
      @(negedge clk);
      rd_en = 0;
      chk("R6 rd_valid", DW'(rd_valid), 1);
      chk(req, rd_data, exp);
      @(negedge clk);
      chk("R6 rd_valid drop", DW'(rd_valid), 0);
   endtask

   task automatic t_stall();
      stall_req = 1; in_valid = 1; in_last = 1; in_data = pat(99);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk("R2 ready", DW'(in_ready), 0);
         chk("R2 count", DW'(beat_count), 0);
         chk("R2 last", DW'(last_flag), 0);
         chk("R2 evt", DW'(evt_valid), 0);
      end
      in_valid = 0; in_last = 0; stall_req = 0;
      @(negedge clk);
      chk("R2 ready back", DW'(in_ready), 1);
   endtask

   task automatic t_stream();
      for (int i = 0; i < 4; i++) send(i, i == 3, i + 1);
      chk("R4 count four", DW'(beat_count), 4);
      chk("R5 last set", DW'(last_flag), 1);
      for (int i = 0; i < 4; i++) readback(i, pat(i), "R3 slot data");
   endtask

   task automatic t_read_unwritten_overlap();
      // slot 6 unwritten; read it while beat 4 is taken
      rd_en = 1; rd_idx = IW'(6);
      in_valid = 1; in_data = pat(4); in_last = 0;
      @(negedge clk);
      rd_en = 0; in_valid = 0;
      chk("R9 count", DW'(beat_count), 5);
      chk("R9 rd_valid", DW'(rd_valid), 1);
      @(negedge clk);
      readback(4, pat(4), "R9 slot4 intact");
   endtask

   task automatic t_fill_and_refuse();
      for (int i = 5; i < DP; i++) send(i, 1'b0, i + 1);
      chk("R5 last sticky", DW'(last_flag), 1);
      chk("R7 full", DW'(buf_full), 1);
      chk("R7 ready", DW'(in_ready), 0);
      in_valid = 1; in_data = pat(77); in_last = 1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R7 count held", DW'(beat_count), DW'(DP));
         chk("R8 no evt", DW'(evt_valid), 0);
      end
      in_valid = 0; in_last = 0;
      for (int i = 0; i < DP; i++) readback(i, pat(i), "R7 slot unchanged");
      chk("R8 evt total", DW'(evt_seen), DW'(DP));
   endtask

   initial begin
      do_reset();
      t_reset_state();
      t_stall();
      t_stream();
      t_read_unwritten_overlap();
      t_fill_and_refuse();
      do_reset();
      t_reset_state();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule